// File: doc/BRIEF.md
# Transfer Byte Counter and Address Tracker

This block follows one data-phase transfer between a host bus and a SCSI bus. Software loads a byte count and a starting address. Two address counters then move on their own.

- The host-side address steps forward whenever the host side fetches ahead. Because of write-ahead buffering, it can run ahead of the bus.
- The bus-side shadow address steps forward only when a byte has actually completed on the bus.
- The byte count is a down-counter. It moves only on those completed bus bytes.

The FIFO, the bus handshake and the DMA engine sit outside this block. Their events arrive here as single-cycle strobes.

Status comes out as two flags:

- a level flag that says the count is zero;
- a sticky flag that records a wrap of the count below zero, cleared by a write-one-to-clear input.

Each flag has its own enable bit. A registered interrupt line is raised when any flag is both set and enabled.

Top module: `xfer_tracker`

## Requirements
- R1: In the cycle after synchronous reset, the count, the host address, the shadow address, the wrap flag and the interrupt are 0, and the zero flag is 1.
- R2: Asserting `cnt_wr_en` loads `cnt_wr_data` into the count on the next edge. Asserting `cnt_clear` sets the count to 0 and takes priority over a load and a decrement in the same cycle.
- R3: Each `byte_done` strobe, with no clear or load that cycle, lowers the count by exactly one. `host_adv` never changes the count.
- R4: `flag_zero` is 1 exactly when the registered count is 0. It changes in the same edge as the count.
- R5: A `byte_done` strobe while the count is 0, with no clear or load that cycle, makes the count all ones and sets the wrap flag.
- R6: The wrap flag stays set until `wrap_clr` is 1. A new wrap event in the same cycle as `wrap_clr` leaves it set.
- R7: Asserting `haddr_wr_en` loads `haddr_wr_data` into both the host address and the shadow address. It takes priority over both advance strobes.
- R8: Each `host_adv` strobe adds one to the host address and leaves the shadow address unchanged.
- R9: Each `byte_done` strobe adds one to the shadow address. This holds when the count wraps and when the count is loaded or cleared in the same cycle.
- R10: When `host_adv` and `byte_done` arrive together, both addresses advance and the count decrements in that same cycle.
- R11: `irq` on a given edge equals the OR over both flags of (flag AND enable), using the flags and `irq_en` from the cycle before. Bit 0 of `irq_en` enables the zero flag and bit 1 enables the wrap flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr_en | input | 1 | Load the byte count |
| cnt_wr_data | input | CNT_W | Value to load into the count |
| cnt_clear | input | 1 | Force the count to zero |
| haddr_wr_en | input | 1 | Load the host and shadow addresses |
| haddr_wr_data | input | ADDR_W | Starting address |
| host_adv | input | 1 | Host side moved one byte |
| byte_done | input | 1 | One byte completed on the bus |
| wrap_clr | input | 1 | Write-one-to-clear for the wrap flag |
| irq_en | input | 2 | Interrupt enables: bit 0 zero flag, bit 1 wrap flag |
| count | output | CNT_W | Remaining byte count |
| host_addr | output | ADDR_W | Host-side (speculative) address |
| shadow_addr | output | ADDR_W | Bus-side committed address |
| flag_zero | output | 1 | Count is zero |
| flag_wrap | output | 1 | Sticky count-wrap flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with an 8-bit count and a 16-bit address instead of the 24-bit and 32-bit defaults. With an 8-bit count, random loads reach zero and wrap below it hundreds of times in a short run, so the wrap flag and its clear race are exercised often. The narrower address lets a preset near the top of the range carry through the wrap-around of both address counters.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int FLAG_ZERO = 0;
  localparam int FLAG_WRAP = 1;
  localparam int NFLAGS    = 2;
endpackage

// File: rtl/xfer_bytecnt.sv
module xfer_bytecnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             zero,
  output logic             wrap_ev
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             zero_q;

  always_comb begin
    cnt_d   = cnt_q;
    wrap_ev = 1'b0;
    if (clear)     cnt_d = '0;
    else if (load) cnt_d = load_val;
    else if (dec) begin
      cnt_d   = cnt_q - 1'b1;
      wrap_ev = (cnt_q == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      zero_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      zero_q <= (cnt_d == '0);
    end
  end

  assign cnt  = cnt_q;
  assign zero = zero_q;
endmodule

// File: rtl/xfer_addrctr.sv
module xfer_addrctr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= load_val;
    else if (inc)  addr_q <= addr_q + 1'b1;
  end

  assign addr = addr_q;
endmodule

// File: rtl/xfer_intr.sv
module xfer_intr
  import xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              zero_lvl,
  input  logic              wrap_set,
  input  logic              wrap_clr,
  input  logic [NFLAGS-1:0] en,
  output logic              flag_wrap,
  output logic              irq
);
  logic              wrap_q, irq_q;
  logic [NFLAGS-1:0] flags;

  always_comb begin
    flags            = '0;
    flags[FLAG_ZERO] = zero_lvl;
    flags[FLAG_WRAP] = wrap_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrap_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wrap_set)      wrap_q <= 1'b1;
      else if (wrap_clr) wrap_q <= 1'b0;
      irq_q <= |(flags & en);
    end
  end

  assign flag_wrap = wrap_q;
  assign irq       = irq_q;
endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker
  import xfer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_wr_en,
  input  logic [CNT_W-1:0]  cnt_wr_data,
  input  logic              cnt_clear,
  input  logic              haddr_wr_en,
  input  logic [ADDR_W-1:0] haddr_wr_data,
  input  logic              host_adv,
  input  logic              byte_done,
  input  logic              wrap_clr,
  input  logic [1:0]        irq_en,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] host_addr,
  output logic [ADDR_W-1:0] shadow_addr,
  output logic              flag_zero,
  output logic              flag_wrap,
  output logic              irq
);
  logic wrap_ev;

  xfer_bytecnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_wr_en), .load_val(cnt_wr_data),
    .clear(cnt_clear), .dec(byte_done), .cnt(count), .zero(flag_zero),
    .wrap_ev(wrap_ev)
  );

  xfer_addrctr #(.ADDR_W(ADDR_W)) u_host (
    .clk(clk), .rst(rst), .load(haddr_wr_en), .load_val(haddr_wr_data),
    .inc(host_adv), .addr(host_addr)
  );

  xfer_addrctr #(.ADDR_W(ADDR_W)) u_shadow (
    .clk(clk), .rst(rst), .load(haddr_wr_en), .load_val(haddr_wr_data),
    .inc(byte_done), .addr(shadow_addr)
  );

  xfer_intr u_intr (
    .clk(clk), .rst(rst), .zero_lvl(flag_zero), .wrap_set(wrap_ev),
    .wrap_clr(wrap_clr), .en(irq_en), .flag_wrap(flag_wrap), .irq(irq)
  );
endmodule

// File: rtl/xfer_tracker_chk.sv
module xfer_tracker_chk #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_wr_en,
  input logic              cnt_clear,
  input logic              haddr_wr_en,
  input logic              host_adv,
  input logic              byte_done,
  input logic              wrap_clr,
  input logic [1:0]        irq_en,
  input logic [CNT_W-1:0]  count,
  input logic [ADDR_W-1:0] host_addr,
  input logic [ADDR_W-1:0] shadow_addr,
  input logic              flag_zero,
  input logic              flag_wrap,
  input logic              irq
);
  p_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !cnt_clear && !cnt_wr_en && count != '0)
      |=> count == $past(count) - 1'b1);

  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    flag_zero == (count == '0));

  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !cnt_clear && !cnt_wr_en && count == '0)
      |=> (flag_wrap && count == '1));

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_wrap && !wrap_clr) |=> flag_wrap);

  p_host_r8: assert property (@(posedge clk) disable iff (rst)
    (host_adv && !haddr_wr_en) |=> host_addr == $past(host_addr) + 1'b1);

  p_shadow_r9: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !haddr_wr_en) |=> shadow_addr == $past(shadow_addr) + 1'b1);

  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!byte_done && !haddr_wr_en) |=> $stable(shadow_addr));

  p_irq_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past((flag_zero & irq_en[0]) | (flag_wrap & irq_en[1])));
endmodule

bind xfer_tracker xfer_tracker_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_wr_en(cnt_wr_en), .cnt_clear(cnt_clear),
  .haddr_wr_en(haddr_wr_en), .host_adv(host_adv), .byte_done(byte_done),
  .wrap_clr(wrap_clr), .irq_en(irq_en), .count(count), .host_addr(host_addr),
  .shadow_addr(shadow_addr), .flag_zero(flag_zero), .flag_wrap(flag_wrap),
  .irq(irq)
);

// File: tb/test_xfer_tracker.sv
module test_xfer_tracker;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cnt_wr_en = 1'b0, cnt_clear = 1'b0, haddr_wr_en = 1'b0;
  logic [CNT_W-1:0]  cnt_wr_data = '0;
  logic [ADDR_W-1:0] haddr_wr_data = '0;
  logic              host_adv = 1'b0, byte_done = 1'b0, wrap_clr = 1'b0;
  logic [1:0]        irq_en = 2'b00;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] host_addr, shadow_addr;
  logic              flag_zero, flag_wrap, irq;

  int n_cmp = 0, n_bad = 0;
  bit started = 0, finished = 0;

  logic [CNT_W-1:0]  m_cnt;
  logic [ADDR_W-1:0] m_host, m_sh;
  logic              m_zero, m_wrap, m_irq;

  always #2.5 clk = ~clk;

  xfer_tracker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_xfer_tracker (
    .clk(clk), .rst(rst), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cnt_clear(cnt_clear), .haddr_wr_en(haddr_wr_en),
    .haddr_wr_data(haddr_wr_data), .host_adv(host_adv), .byte_done(byte_done),
    .wrap_clr(wrap_clr), .irq_en(irq_en), .count(count), .host_addr(host_addr),
    .shadow_addr(shadow_addr), .flag_zero(flag_zero), .flag_wrap(flag_wrap),
    .irq(irq)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: next state from the requirements
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '0; m_host = '0; m_sh = '0;
      m_zero = 1'b1; m_wrap = 1'b0; m_irq = 1'b0;
    end else begin
      bit ev;
      m_irq = (m_zero && irq_en[0]) || (m_wrap && irq_en[1]);
      ev = !cnt_clear && !cnt_wr_en && byte_done && (m_cnt == 0);
      if (cnt_clear)      m_cnt = '0;
      else if (cnt_wr_en) m_cnt = cnt_wr_data;
      else if (byte_done) m_cnt = m_cnt - 1;
      m_zero = (m_cnt == 0);
      if (ev)            m_wrap = 1'b1;
      else if (wrap_clr) m_wrap = 1'b0;
      if (haddr_wr_en) begin
        m_host = haddr_wr_data; m_sh = haddr_wr_data;
      end else begin
        if (host_adv)  m_host = m_host + 1;
        if (byte_done) m_sh = m_sh + 1;
      end
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R3 count", count, m_cnt);
      chk("R4 zero flag", flag_zero, m_zero);
      chk("R6 wrap flag", flag_wrap, m_wrap);
      chk("R8 host address", host_addr, m_host);
      chk("R9 shadow address", shadow_addr, m_sh);
      chk("R11 irq", irq, m_irq);
    end
  end

  task automatic step(input bit cw, input int cwd, input bit cc, input bit hw,
                      input int hwd, input bit ha, input bit bd, input bit wc,
                      input logic [1:0] en);
    cnt_wr_en = cw; cnt_wr_data = CNT_W'(cwd); cnt_clear = cc;
    haddr_wr_en = hw; haddr_wr_data = ADDR_W'(hwd); host_adv = ha;
    byte_done = bd; wrap_clr = wc; irq_en = en;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 zero", flag_zero, 1);
    chk("R1 wrap", flag_wrap, 0);
    chk("R1 host", host_addr, 0);
    chk("R1 shadow", shadow_addr, 0);
    chk("R1 irq", irq, 0);
    // R2 load, then clear beats load
    step(1, 3, 0, 0, 0, 0, 0, 0, 2'b00);
    chk("R2 load", count, 3);
    chk("R4 nonzero", flag_zero, 0);
    step(1, 9, 1, 0, 0, 0, 0, 0, 2'b00);
    chk("R2 clear priority", count, 0);
    // R7 address load
    step(1, 2, 0, 1, 'h100, 0, 0, 0, 2'b00);
    chk("R7 host load", host_addr, 'h100);
    chk("R7 shadow load", shadow_addr, 'h100);
    // R8 host advance only
    step(0, 0, 0, 0, 0, 1, 0, 0, 2'b00);
    step(0, 0, 0, 0, 0, 1, 0, 0, 2'b00);
    step(0, 0, 0, 0, 0, 1, 0, 0, 2'b00);
    chk("R8 host ahead", host_addr, 'h103);
    chk("R8 shadow held", shadow_addr, 'h100);
    chk("R3 count untouched by host_adv", count, 2);
    // R10 both strobes
    step(0, 0, 0, 0, 0, 1, 1, 0, 2'b00);
    chk("R10 host", host_addr, 'h104);
    chk("R10 shadow", shadow_addr, 'h101);
    chk("R10 count", count, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0, 2'b00);
    chk("R4 zero reached", flag_zero, 1);
    // R5 wrap below zero, R9 shadow still advances
    step(0, 0, 0, 0, 0, 0, 1, 0, 2'b00);
    chk("R5 count all ones", count, 'hFF);
    chk("R5 wrap set", flag_wrap, 1);
    chk("R9 shadow on wrap", shadow_addr, 'h103);
    // R11 irq one cycle after enable
    step(0, 0, 0, 0, 0, 0, 0, 0, 2'b10);
    chk("R11 irq wrap enabled", irq, 1);
    // R6 clear, then set wins over clear
    step(0, 0, 0, 0, 0, 0, 1, 1, 2'b00);
    chk("R6 wrap cleared", flag_wrap, 0);
    chk("R11 irq masked", irq, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 2'b00);
    step(0, 0, 0, 0, 0, 0, 1, 1, 2'b00);
    chk("R6 set beats clear", flag_wrap, 1);
    // R9 shadow advances while count loaded
    step(1, 5, 0, 1, 'hFFFE, 0, 0, 0, 2'b00);
    step(1, 7, 0, 0, 0, 1, 1, 0, 2'b00);
    chk("R9 shadow with load", shadow_addr, 'hFFFF);
    chk("R2 load beats decrement", count, 7);
    step(0, 0, 0, 0, 0, 1, 1, 0, 2'b00);
    chk("R9 shadow rolls over", shadow_addr, 0);
    // Random traffic, compared every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 4, $urandom, r >= 97, ($urandom_range(0, 99) < 2), $urandom,
           $urandom_range(0, 1), ($urandom_range(0, 9) < 6),
           ($urandom_range(0, 9) == 0), 2'($urandom));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 2'b00);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule